// File: doc/BRIEF.md
# Two-Port Address Collision Arbiter

This block sits beside a two-port memory array and watches the two access ports, called left and right. When both ports are selected and present the same address, it decides which port keeps the location and marks the other with an active-low busy flag. The losing port may still read. Its writes are held off until the two addresses part.

A mode strap sets how the busy pins behave. In master mode the block drives its own busy flags outward, and its arbitration decision gates the writes. In slave mode the block drives nothing outward. It takes busy from outside instead, from a master that serves the same address lines, and those inputs gate the writes. This lets several arrays be placed side by side to build a wider word while one master arbitrates for all of them. The busy pins carry control, not data, so there is no valid/ready handshake. Every output is combinational from the present inputs and one cycle of registered history, so a busy flag or a write grant is valid in the same cycle as the access that causes it.

Top module: `busyarb_top`

## Requirements
- R1: A collision exists only while both `l_sel` and `r_sel` are high and `l_addr` equals `r_addr`. Without a collision, both `busy_out_*_n` are high and each `*_wr_ok` equals `*_sel & *_wr`.
- R2: In master mode (`master_mode`=1), during a collision exactly one `busy_out_*_n` is low, the loser's, and this holds whether the loser is reading or writing.
- R3: A port counts as "old" when it was selected in the previous cycle at the same address it presents now. When a collision begins, an old port wins against a fresh one.
- R4: When a collision begins and both ports are old or both are fresh, the left port wins, so `busy_out_r_n` goes low.
- R5: The loser stays the same for every consecutive cycle of a collision, even if the ages change. Busy is released in the first cycle without a collision.
- R6: In master mode the loser's `*_wr_ok` is low during the collision. The winner's writes are granted.
- R7: In master mode the `busy_in_*_n` inputs have no effect on any output.
- R8: In slave mode (`master_mode`=0), both `busy_out_*_n` stay high. `*_wr_ok` = `*_sel & *_wr & busy_in_*_n`, whatever the state of the collision.
- R9: `busy_drive` equals `master_mode`. After reset no port is old, and no collision is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | Strap: 1 = master (drives busy), 0 = slave (receives busy) |
| l_sel | input | 1 | Left port selected |
| l_wr | input | 1 | Left port write request |
| l_addr | input | ADDR_W | Left port address |
| r_sel | input | 1 | Right port selected |
| r_wr | input | 1 | Right port write request |
| r_addr | input | ADDR_W | Right port address |
| busy_in_l_n | input | 1 | External busy for the left port in slave mode, active low |
| busy_in_r_n | input | 1 | External busy for the right port in slave mode, active low |
| busy_out_l_n | output | 1 | Left port lost arbitration, active low |
| busy_out_r_n | output | 1 | Right port lost arbitration, active low |
| busy_drive | output | 1 | Output enable for the busy pad drivers |
| l_wr_ok | output | 1 | Left write is granted to the array |
| r_wr_ok | output | 1 | Right write is granted to the array |

## Verification
The state in this block is each port's previous select and address, plus the held collision and its loser. If the age history is wrong, the wrong port gets busy in the very cycle a collision begins. If the held loser is wrong, the result shows one cycle later, when busy moves to the other port partway through a collision or stays low after the addresses part. Either fault also shows as a write grant on the wrong port in the same cycle. A reference model compares every output on every cycle, so such a fault is reported in the cycle where it first shows.

// File: rtl/busyarb_pkg.sv
package busyarb_pkg;
  localparam int NPORTS = 2;
  localparam int P_LEFT  = 0;
  localparam int P_RIGHT = 1;

  typedef enum logic [1:0] {
    SIDE_NONE  = 2'd0,
    SIDE_LEFT  = 2'd1,
    SIDE_RIGHT = 2'd2
  } side_e;
endpackage

// File: rtl/busyarb_age.sv
// Remembers whether a port was selected at its present address last cycle.
module busyarb_age #(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic              old
);
  logic              sel_q;
  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      sel_q  <= sel;
      addr_q <= addr;
    end
  end

  assign old = sel_q & sel & (addr_q == addr);
endmodule

// File: rtl/busyarb_match.sv
// Collision detect: both ports enabled on one address.
module busyarb_match #(
  parameter int ADDR_W = 12
) (
  input  logic              a_sel,
  input  logic              b_sel,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [ADDR_W-1:0] b_addr,
  output logic              hit
);
  logic same;
  assign same = (a_addr == b_addr);
  assign hit  = a_sel & b_sel & same;
endmodule

// File: rtl/busyarb_decide.sv
// Picks the loser when a collision starts and holds it while it lasts.
module busyarb_decide
  import busyarb_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  hit,
  input  logic  old_l,
  input  logic  old_r,
  output side_e loser
);
  logic  hit_q;
  side_e loser_q;
  side_e fresh_loser;

  always_comb begin
    if (old_r && !old_l) fresh_loser = SIDE_LEFT;
    else                 fresh_loser = SIDE_RIGHT;
  end

  always_comb begin
    if (!hit)       loser = SIDE_NONE;
    else if (hit_q) loser = loser_q;
    else            loser = fresh_loser;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q   <= 1'b0;
      loser_q <= SIDE_NONE;
    end else begin
      hit_q   <= hit;
      loser_q <= loser;
    end
  end
endmodule

// File: rtl/busyarb_gate.sv
// Per-port busy pin and write gating, chosen by the mode strap.
module busyarb_gate (
  input  logic master_mode,
  input  logic lost,
  input  logic busy_in_n,
  input  logic sel,
  input  logic wr,
  output logic busy_out_n,
  output logic wr_ok
);
  logic inhibit;

  always_comb begin
    if (master_mode) begin
      inhibit    = lost;
      busy_out_n = ~lost;
    end else begin
      inhibit    = ~busy_in_n;
      busy_out_n = 1'b1;
    end
  end

  assign wr_ok = sel & wr & ~inhibit;
endmodule

// File: rtl/busyarb_top.sv
module busyarb_top
  import busyarb_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_sel,
  input  logic              l_wr,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              busy_in_l_n,
  input  logic              busy_in_r_n,
  output logic              busy_out_l_n,
  output logic              busy_out_r_n,
  output logic              busy_drive,
  output logic              l_wr_ok,
  output logic              r_wr_ok
);
  logic [NPORTS-1:0]             p_sel, p_wr, p_bin_n, p_old, p_lost, p_bout_n, p_ok;
  logic [NPORTS-1:0][ADDR_W-1:0] p_addr;
  logic                          hit;
  side_e                         loser;

  assign p_sel   = {r_sel, l_sel};
  assign p_wr    = {r_wr, l_wr};
  assign p_bin_n = {busy_in_r_n, busy_in_l_n};
  assign p_addr  = {r_addr, l_addr};
  assign p_lost  = {loser == SIDE_RIGHT, loser == SIDE_LEFT};

  busyarb_match #(.ADDR_W(ADDR_W)) u_match (
    .a_sel(l_sel), .b_sel(r_sel), .a_addr(l_addr), .b_addr(r_addr), .hit(hit)
  );

  busyarb_decide u_decide (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .old_l(p_old[P_LEFT]), .old_r(p_old[P_RIGHT]), .loser(loser)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    busyarb_age #(.ADDR_W(ADDR_W)) u_age (
      .clk(clk), .rst_n(rst_n), .sel(p_sel[p]), .addr(p_addr[p]), .old(p_old[p])
    );
    busyarb_gate u_gate (
      .master_mode(master_mode), .lost(p_lost[p]), .busy_in_n(p_bin_n[p]),
      .sel(p_sel[p]), .wr(p_wr[p]), .busy_out_n(p_bout_n[p]), .wr_ok(p_ok[p])
    );
  end

  assign busy_out_l_n = p_bout_n[P_LEFT];
  assign busy_out_r_n = p_bout_n[P_RIGHT];
  assign l_wr_ok      = p_ok[P_LEFT];
  assign r_wr_ok      = p_ok[P_RIGHT];
  assign busy_drive   = master_mode;
endmodule

// File: rtl/busyarb_chk.sv
module busyarb_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              master_mode,
  input logic              l_sel,
  input logic              l_wr,
  input logic [ADDR_W-1:0] l_addr,
  input logic              r_sel,
  input logic              r_wr,
  input logic [ADDR_W-1:0] r_addr,
  input logic              busy_in_l_n,
  input logic              busy_in_r_n,
  input logic              busy_out_l_n,
  input logic              busy_out_r_n,
  input logic              busy_drive,
  input logic              l_wr_ok,
  input logic              r_wr_ok
);
  logic seen;
  logic coll;
  assign coll = l_sel && r_sel && (l_addr == r_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  AST_BUSY_NEEDS_COLLISION: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_out_l_n || !busy_out_r_n) |-> coll);  // R1

  AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && coll) |-> $countones({busy_out_l_n, busy_out_r_n}) == 1);  // R2

  AST_LOSER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && master_mode && $past(master_mode) && coll && $past(coll))
      |-> ($stable(busy_out_l_n) && $stable(busy_out_r_n)));  // R5

  AST_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && (!busy_out_l_n || !busy_out_r_n))
      |-> !((!busy_out_l_n && l_wr_ok) || (!busy_out_r_n && r_wr_ok)));  // R6

  AST_SLAVE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (busy_out_l_n && busy_out_r_n && !busy_drive));  // R8

  AST_SLAVE_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && (!busy_in_l_n || !busy_in_r_n))
      |-> !((!busy_in_l_n && l_wr_ok) || (!busy_in_r_n && r_wr_ok)));  // R8
endmodule

bind busyarb_top busyarb_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
  .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr),
  .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr),
  .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
  .busy_out_l_n(busy_out_l_n), .busy_out_r_n(busy_out_r_n),
  .busy_drive(busy_drive), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
);

// File: tb/busyarb_top_tb.sv
module busyarb_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic master_mode = 1'b1;
  logic l_sel = 0, l_wr = 0, r_sel = 0, r_wr = 0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic busy_in_l_n = 1, busy_in_r_n = 1;
  logic busy_out_l_n, busy_out_r_n, busy_drive, l_wr_ok, r_wr_ok;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state: 0 none, 1 left, 2 right
  bit m_pl_sel = 0, m_pr_sel = 0, m_hit = 0;
  int m_pl_addr = 0, m_pr_addr = 0, m_loser = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busyarb_top #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .master_mode(master_mode),
    .l_sel(l_sel), .l_wr(l_wr), .l_addr(l_addr),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr),
    .busy_in_l_n(busy_in_l_n), .busy_in_r_n(busy_in_r_n),
    .busy_out_l_n(busy_out_l_n), .busy_out_r_n(busy_out_r_n),
    .busy_drive(busy_drive), .l_wr_ok(l_wr_ok), .r_wr_ok(r_wr_ok)
  );

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit ms, input bit ls, input bit lw, input int la,
                      input bit rs, input bit rw, input int ra,
                      input bit bil, input bit bir, input string tag);
    bit hit, oldl, oldr, inh_l, inh_r;
    int loser;
    @(negedge clk);
    master_mode = ms; l_sel = ls; l_wr = lw; l_addr = la[AW-1:0];
    r_sel = rs; r_wr = rw; r_addr = ra[AW-1:0];
    busy_in_l_n = bil; busy_in_r_n = bir;
    #1;
    hit = ls && rs && (la == ra);
    loser = 0;
    if (hit) begin
      if (m_hit) loser = m_loser;
      else begin
        oldl = m_pl_sel && ls && (m_pl_addr == la);
        oldr = m_pr_sel && rs && (m_pr_addr == ra);
        loser = (oldr && !oldl) ? 1 : 2;
      end
    end
    inh_l = ms ? (loser == 1) : !bil;
    inh_r = ms ? (loser == 2) : !bir;
    chk(tag, "busy_out_l_n", busy_out_l_n, ms ? !(loser == 1) : 1'b1);
    chk(tag, "busy_out_r_n", busy_out_r_n, ms ? !(loser == 2) : 1'b1);
    chk(tag, "l_wr_ok", l_wr_ok, ls && lw && !inh_l);
    chk(tag, "r_wr_ok", r_wr_ok, rs && rw && !inh_r);
    chk(tag, "busy_drive", busy_drive, ms);
    @(posedge clk);
    m_pl_sel = ls; m_pl_addr = la; m_pr_sel = rs; m_pr_addr = ra;
    m_hit = hit; m_loser = loser;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9: idle after reset, master strap drives busy
    step(1, 0,0,0, 0,0,0, 1,1, "R9");
    // R1: single port, then different addresses
    step(1, 1,1,5, 0,0,0, 1,1, "R1");
    step(1, 1,1,5, 1,1,6, 1,1, "R1");
    step(1, 1,1,9, 0,1,9, 1,1, "R1");   // same address, right not selected
    step(1, 0,0,0, 0,0,0, 1,1, "R1");
    // R4: both fresh on one address -> right loses; R6 write blocked
    step(1, 1,1,8, 1,1,8, 1,1, "R4");
    step(1, 1,1,8, 1,1,8, 1,1, "R5");
    step(1, 1,0,8, 1,1,8, 0,0, "R7");   // busy inputs ignored in master
    step(1, 1,1,8, 1,1,3, 1,1, "R5");   // release
    // R3: right old at 7, left joins -> left loses
    step(1, 0,0,0, 1,0,7, 1,1, "R3");
    step(1, 1,1,7, 1,1,7, 1,1, "R3");
    step(1, 1,1,7, 1,0,7, 1,1, "R5");
    step(1, 1,1,7, 1,1,7, 1,1, "R6");
    step(1, 0,0,7, 1,1,7, 1,1, "R5");
    // R3: left old, right fresh -> right loses, reading loser still busy (R2)
    step(1, 1,0,2, 0,0,0, 1,1, "R3");
    step(1, 1,0,2, 1,0,2, 1,1, "R2");
    step(1, 1,1,2, 1,1,2, 1,1, "R6");
    step(1, 0,0,0, 0,0,0, 1,1, "R5");
    // R4: both old on different addresses, then both move to one -> fresh tie
    step(1, 1,0,4, 1,0,6, 1,1, "R4");
    step(1, 1,1,1, 1,1,1, 1,1, "R4");
    // R8: slave mode
    step(0, 1,1,1, 1,1,1, 1,1, "R8");
    step(0, 1,1,1, 1,1,1, 1,0, "R8");
    step(0, 1,1,1, 1,1,1, 0,1, "R8");
    step(0, 1,1,3, 0,1,3, 0,0, "R8");
    // R9: busy_drive follows the strap back
    step(1, 0,0,0, 0,0,0, 1,1, "R9");
    // R2: random traffic on a small address range, both modes
    for (int i = 0; i < 400; i++) begin
      step(($urandom % 5) != 0, $urandom % 4 != 0, $urandom % 2, $urandom % 3,
           $urandom % 4 != 0, $urandom % 2, $urandom % 3,
           $urandom % 2, $urandom % 2, "R2");
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule